// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the command wire of an SD or eMMC bus. When a start strobe is accepted, it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument, adds a CRC7 checksum, and shifts the frame out most significant bit first. If the selected response kind asks for it, the engine then releases the wire and waits for the card's reply. The reply is shifted into a 136-bit response register and checked for index, CRC and end-bit faults.

The engine runs on the system clock. All bus activity advances only on cycles where the SD-clock-rate enable `sd_ce` is high. The engine reads the wire back while it drives a 1. If it sees a 0, another driver is fighting it, so it abandons the command. A reply that never starts is reported as a timeout after a fixed number of SD clock samples. The data lines, SD clock generation and register access sit outside this block.

Top module: `sdcmd_engine`

## Requirements
- R1: A start strobe that is accepted loads the frame {0, 1, index[5:0], argument[31:0], crc7[6:0], 1}. Bit 47 is sent first, one bit per `sd_ce` cycle. The CRC7 uses x^7+x^3+1 over frame bits 47..8, starting from zero. `cmd_oe` is high for the whole frame, and the first bit appears in the cycle after the accepting edge.
- R2: `rsp_kind` is decoded as 00 = no response, 01 = 136-bit, 10 = 48-bit, 11 = 48-bit (the busy wait that follows belongs to the data side). For kind 00, `done` pulses in the cycle after the end bit is sent, and the engine returns to idle without listening.
- R3: For kinds 10 and 11, the engine listens after the end bit. The first 0 it samples is taken as the start bit, and 48 bits in total are shifted in. When the final bit is sampled, `done` pulses and `resp[47:0]` holds the reply, with its start bit at bit 47 and the upper bits zero.
- R4: For kind 01, 136 bits are received into `resp[135:0]`. The CRC is checked over reply bits 127..8 against bits 7..1, and no index error is ever raised.
- R5: If none of the 64 `sd_ce` samples after the command end bit is 0, `err_timeout` pulses on the 64th sample, `done` stays low, and the engine goes idle. A start bit on the 64th sample is still accepted.
- R6: If the engine is driving a 1 and samples a 0 on the wire, it releases the wire at once, returns to idle, and pulses `err_crc` and `err_timeout` together, with no `done`.
- R7: When `idx_chk_en` is set and the kind is not 01, a reply index (bits 45..40) that differs from the issued index pulses `err_index` together with `done`. When `idx_chk_en` is clear, no index error is raised.
- R8: When `crc_chk_en` is set, a reply CRC that differs from the computed one pulses `err_crc` together with `done`. When `crc_chk_en` is clear, CRC mismatches are not reported.
- R9: A reply whose last bit is 0 pulses `err_endbit` together with `done`.
- R10: `busy` is high from the accepting edge until completion or an error. A start strobe while busy is ignored: the frame in flight is unchanged and no second command follows.
- R11: `rst` or `srst` returns the engine to idle, releases the wire (`cmd_oe`=0, `cmd_out`=1), and clears `resp`, `done` and all error flags.
- R12: A start is accepted only on a cycle where `sd_ce` is high. `done` and the error flags are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| srst | input | 1 | Synchronous soft reset back to idle |
| sd_ce | input | 1 | SD-clock-rate enable |
| start | input | 1 | Command start strobe |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | Response kind select |
| idx_chk_en | input | 1 | Enable reply index check |
| crc_chk_en | input | 1 | Enable reply CRC check |
| cmd_in | input | 1 | Sampled level of the command wire |
| cmd_out | output | 1 | Drive level for the command wire |
| cmd_oe | output | 1 | Drive enable for the command wire |
| busy | output | 1 | Command or reply in progress |
| resp | output | 136 | Received reply, right-aligned |
| done | output | 1 | Command complete pulse |
| err_timeout | output | 1 | Timeout error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_endbit | output | 1 | End-bit error pulse |
| err_index | output | 1 | Index error pulse |

## Verification
With `sd_ce` high every cycle, the timing is fixed. Frame bit 47-k is on `cmd_out` after the k-th edge that follows acceptance. The no-response `done` is visible after the 48th edge. The first listening sample is taken at the 49th edge. A timeout shows after the 112th edge. Reply flags and `done` appear right after the edge that samples the final reply bit, and a wire conflict is flagged right after the edge that sees it. The bench drives all inputs on falling edges and steps through exactly these edge counts before each sample, so every check lands in the single cycle where a result is due.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_W  = 48;
    localparam int HDR_W    = 40;
    localparam int CRC_W    = 7;
    localparam int SHORT_W  = 48;
    localparam int LONG_W   = 136;
    localparam int LONG_HDR = 8;
    localparam int IDX_W    = 6;
    localparam int ARG_W    = 32;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } eng_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        rsp_kind_e        kind;
        logic             idx_chk;
        logic             crc_chk;
    } cmd_req_t;

    typedef struct packed {
        logic tmo;
        logic crc;
        logic endb;
        logic idx;
    } err_flags_t;

    // One serial step of x^7 + x^3 + 1.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    function automatic logic [CRC_W-1:0] crc7_of_hdr(input logic [HDR_W-1:0] h);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            c = crc7_step(c, h[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic               ce,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               line_in,
    output logic               drv_lvl,
    output logic               drv_en,
    output logic               last,
    output logic               conflict
);
    localparam int CW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      cnt;
    logic               active;

    // A driven 1 read back as 0 means another driver holds the wire.
    assign conflict = active && ce && sh[FRAME_W-1] && !line_in;
    assign last     = active && ce && !conflict && (cnt == CW'(FRAME_W - 1));
    assign drv_en   = active;
    assign drv_lvl  = active ? sh[FRAME_W-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (clr) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= frame;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && ce) begin
            if (conflict || last) begin
                active <= 1'b0;
            end else begin
                sh  <= {sh[FRAME_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdcmd_tmo.sv
module sdcmd_tmo #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (tick && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              ce,
    input  logic              arm,
    input  logic              en,
    input  logic              long_sel,
    input  logic [IDX_W-1:0]  exp_idx,
    input  logic              idx_chk,
    input  logic              crc_chk,
    input  logic              line_in,
    output logic [LONG_W-1:0] resp,
    output logic              fin,
    output logic              bad_crc,
    output logic              bad_end,
    output logic              bad_idx
);
    localparam int CNT_W = $clog2(LONG_W + 1);
    localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(LONG_HDR + 1);
    localparam logic [CNT_W-1:0] WIN_HIL = CNT_W'(LONG_W - 8);
    localparam logic [CNT_W-1:0] WIN_HIS = CNT_W'(SHORT_W - 8);

    logic [LONG_W-1:0] sh, sh_n;
    logic [CNT_W-1:0]  n, n_new, len;
    logic [CRC_W-1:0]  crc;
    logic              in_win;

    assign sh_n   = {sh[LONG_W-2:0], line_in};
    assign n_new  = n + 1'b1;
    assign len    = long_sel ? LEN_L : LEN_S;
    assign in_win = long_sel ? (n_new >= WIN_LO && n_new <= WIN_HIL) : (n_new <= WIN_HIS);
    assign fin    = en && ce && (n_new == len);

    // Checks read the next-state image so flags coincide with the final bit.
    assign bad_end = !line_in;
    assign bad_crc = crc_chk && (crc != sh_n[7:1]);
    assign bad_idx = idx_chk && !long_sel && (sh_n[45:40] != exp_idx);
    assign resp    = sh;

    always_ff @(posedge clk) begin
        if (clr) begin
            sh  <= '0;
            n   <= '0;
            crc <= '0;
        end else if (arm) begin
            // The start bit is 0; it leaves a zero-seeded CRC at zero.
            sh  <= '0;
            n   <= CNT_W'(1);
            crc <= '0;
        end else if (en && ce) begin
            sh <= sh_n;
            n  <= n_new;
            if (in_win) begin
                crc <= crc7_step(crc, line_in);
            end
        end
    end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TMO_SAMPLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              sd_ce,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [1:0]        rsp_kind,
    input  logic              idx_chk_en,
    input  logic              crc_chk_en,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic [LONG_W-1:0] resp,
    output logic              done,
    output logic              err_timeout,
    output logic              err_crc,
    output logic              err_endbit,
    output logic              err_index
);
    logic               rst_any;
    eng_state_e         state;
    cmd_req_t           req, new_req;
    err_flags_t         err;
    logic               accept;
    logic [HDR_W-1:0]   hdr;
    logic [FRAME_W-1:0] frame;
    logic               tx_last, tx_conflict;
    logic               waiting, rx_arm, tmo_hit;
    logic               rx_fin, rx_bad_crc, rx_bad_end, rx_bad_idx;

    assign rst_any = rst | srst;
    assign accept  = (state == ST_IDLE) && sd_ce && start;
    assign new_req = '{idx: cmd_idx, kind: rsp_kind_e'(rsp_kind),
                       idx_chk: idx_chk_en, crc_chk: crc_chk_en};
    assign hdr     = {2'b01, cmd_idx, cmd_arg};
    assign frame   = {hdr, crc7_of_hdr(hdr), 1'b1};
    assign waiting = (state == ST_WAIT);
    assign rx_arm  = waiting && sd_ce && !cmd_in;
    assign busy    = (state != ST_IDLE);

    sdcmd_tx u_tx (
        .clk      (clk),
        .clr      (rst_any),
        .ce       (sd_ce),
        .load     (accept),
        .frame    (frame),
        .line_in  (cmd_in),
        .drv_lvl  (cmd_out),
        .drv_en   (cmd_oe),
        .last     (tx_last),
        .conflict (tx_conflict)
    );

    sdcmd_tmo #(.LIMIT(TMO_SAMPLES)) u_tmo (
        .clk    (clk),
        .clr    (rst_any | accept),
        .tick   (waiting && sd_ce && cmd_in),
        .expire (tmo_hit)
    );

    sdcmd_rx u_rx (
        .clk      (clk),
        .clr      (rst_any),
        .ce       (sd_ce),
        .arm      (rx_arm),
        .en       (state == ST_RECV),
        .long_sel (req.kind == RSP_LONG),
        .exp_idx  (req.idx),
        .idx_chk  (req.idx_chk),
        .crc_chk  (req.crc_chk),
        .line_in  (cmd_in),
        .resp     (resp),
        .fin      (rx_fin),
        .bad_crc  (rx_bad_crc),
        .bad_end  (rx_bad_end),
        .bad_idx  (rx_bad_idx)
    );

    always_ff @(posedge clk) begin
        if (rst_any) begin
            state <= ST_IDLE;
            req   <= '0;
            done  <= 1'b0;
            err   <= '0;
        end else begin
            done <= 1'b0;
            err  <= '0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SEND;
                        req   <= new_req;
                    end
                end
                ST_SEND: begin
                    if (tx_conflict) begin
                        state   <= ST_IDLE;
                        err.tmo <= 1'b1;
                        err.crc <= 1'b1;
                    end else if (tx_last) begin
                        if (req.kind == RSP_NONE) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rx_arm) begin
                        state <= ST_RECV;
                    end else if (tmo_hit) begin
                        state   <= ST_IDLE;
                        err.tmo <= 1'b1;
                    end
                end
                ST_RECV: begin
                    if (rx_fin) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        err.crc  <= rx_bad_crc;
                        err.endb <= rx_bad_end;
                        err.idx  <= rx_bad_idx;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign err_timeout = err.tmo;
    assign err_crc     = err.crc;
    assign err_endbit  = err.endb;
    assign err_index   = err.idx;

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic clk,
    input logic rst,
    input logic srst,
    input logic cmd_oe,
    input logic busy,
    input logic done,
    input logic err_timeout,
    input logic err_crc,
    input logic err_endbit,
    input logic err_index
);

    // R10
    oe_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> busy);

    // R2
    done_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !cmd_oe));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    timeout_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> !done);

    // R7
    index_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_index |-> done);

    // R9
    endbit_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_endbit |-> done);

    // R6
    conflict_release_chk: assert property (@(posedge clk) disable iff (rst)
        (err_crc && err_timeout) |-> (!cmd_oe && !busy && !done));

    // R10
    busy_end_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(srst)) |-> (done || err_timeout));

    // R11
    soft_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!busy && !cmd_oe && !done && !err_timeout && !err_crc));

endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (.*);

// File: tb/sdcmd_engine_bench.sv
module sdcmd_engine_bench;

    logic         clk = 1'b0;
    logic         rst, srst, sd_ce, start;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic [1:0]   rsp_kind;
    logic         idx_chk_en, crc_chk_en;
    logic         cmd_in, cmd_out, cmd_oe, busy;
    logic [135:0] resp;
    logic         done, err_timeout, err_crc, err_endbit, err_index;
    logic         card_lvl, jam;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    // Wired command line: own drive (possibly jammed low) or the card side.
    assign cmd_in = cmd_oe ? (cmd_out & ~jam) : card_lvl;

    sdcmd_engine u_sdcmd_engine (
        .clk(clk), .rst(rst), .srst(srst), .sd_ce(sd_ce), .start(start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
        .idx_chk_en(idx_chk_en), .crc_chk_en(crc_chk_en), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .resp(resp),
        .done(done), .err_timeout(err_timeout), .err_crc(err_crc),
        .err_endbit(err_endbit), .err_index(err_index)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  kind;
        logic        ic;
        logic        cc;
        logic [5:0]  ridx;
        logic [31:0] rpay;
        logic        crc_bad;
        logic        endv;
        logic [6:0]  dly;
        logic        e_crc;
        logic        e_end;
        logic        e_idx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{6'd17, 32'h00001000, 2'b10, 1'b1, 1'b1, 6'd17, 32'h00000900, 1'b0, 1'b1, 7'd2,  1'b0, 1'b0, 1'b0},
        '{6'd55, 32'hDEADBEEF, 2'b11, 1'b1, 1'b1, 6'd55, 32'h00000120, 1'b0, 1'b1, 7'd0,  1'b0, 1'b0, 1'b0},
        '{6'd8,  32'h000001AA, 2'b10, 1'b1, 1'b1, 6'd9,  32'h000001AA, 1'b0, 1'b1, 7'd5,  1'b0, 1'b0, 1'b1},
        '{6'd8,  32'h000001AA, 2'b10, 1'b0, 1'b1, 6'd9,  32'h000001AA, 1'b0, 1'b1, 7'd5,  1'b0, 1'b0, 1'b0},
        '{6'd13, 32'h00020000, 2'b10, 1'b1, 1'b1, 6'd13, 32'h00000B00, 1'b1, 1'b1, 7'd1,  1'b1, 1'b0, 1'b0},
        '{6'd13, 32'h00020000, 2'b10, 1'b1, 1'b0, 6'd13, 32'h00000B00, 1'b1, 1'b1, 7'd1,  1'b0, 1'b0, 1'b0},
        '{6'd7,  32'hFFFF0000, 2'b10, 1'b1, 1'b1, 6'd7,  32'h00000700, 1'b0, 1'b0, 7'd3,  1'b0, 1'b1, 1'b0},
        '{6'd16, 32'h00000200, 2'b11, 1'b1, 1'b1, 6'd16, 32'h00000900, 1'b0, 1'b1, 7'd63, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Bench-side CRC7: divide the n low bits of v, msb first, by 0x89.
    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
        logic [7:0] r;
        r = 8'h00;
        for (int i = n - 1; i >= 0; i--) begin
            r = {r[6:0], 1'b0};
            if (r[7] ^ v[i]) r = r ^ 8'h09;
            r[7] = 1'b0;
        end
        return r[6:0];
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h;
        h = {2'b01, idx, arg};
        return {h, ref_crc({96'd0, h}, 40), 1'b1};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                            input bit ic, input bit cc, input bit poke,
                            output logic [47:0] got, output bit oe_ok);
        @(negedge clk);
        cmd_idx = idx; cmd_arg = arg; rsp_kind = kind;
        idx_chk_en = ic; crc_chk_en = cc; start = 1'b1;
        step();
        start = 1'b0;
        oe_ok = 1'b1;
        for (int i = 47; i >= 0; i--) begin
            got[i] = cmd_out;
            if (!cmd_oe) oe_ok = 1'b0;
            if (poke && i == 37) begin
                start = 1'b1;
                cmd_idx = ~idx;
            end else begin
                start = 1'b0;
            end
            step();
        end
        start = 1'b0;
    endtask

    task automatic card_reply(input logic [135:0] bits, input int len, input int dly);
        for (int k = 0; k < dly; k++) begin
            card_lvl = 1'b1;
            step();
        end
        for (int k = len - 1; k >= 0; k--) begin
            card_lvl = bits[k];
            step();
        end
        card_lvl = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0]  got;
        bit           oe_ok;
        logic [39:0]  core;
        logic [47:0]  rsp48;
        logic [135:0] rsp136;
        logic [119:0] pay;
        bit           seen;

        rst = 1'b1; srst = 1'b0; sd_ce = 1'b1; start = 1'b0;
        cmd_idx = '0; cmd_arg = '0; rsp_kind = 2'b00;
        idx_chk_en = 1'b0; crc_chk_en = 1'b0; card_lvl = 1'b1; jam = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R11 reset state
        check(!busy && !cmd_oe && cmd_out, "R11 reset idle", {busy, cmd_oe, cmd_out}, 3'b001);
        check(!done && !err_timeout && !err_crc && !err_endbit && !err_index, "R11 reset flags",
              {done, err_timeout, err_crc, err_endbit, err_index}, 0);
        check(resp == '0, "R11 reset resp", resp, 0);

        // Vector table: 48-bit replies
        for (int v = 0; v < NV; v++) begin
            send_cmd(VECS[v].idx, VECS[v].arg, VECS[v].kind, VECS[v].ic, VECS[v].cc, 1'b0, got, oe_ok);
            check(got == ref_frame(VECS[v].idx, VECS[v].arg), "R1 frame", got, ref_frame(VECS[v].idx, VECS[v].arg));
            check(oe_ok, "R1 drive enable", oe_ok, 1);
            core  = {2'b00, VECS[v].ridx, VECS[v].rpay};
            rsp48 = {core, ref_crc({96'd0, core}, 40) ^ {6'd0, VECS[v].crc_bad}, VECS[v].endv};
            card_reply({88'd0, rsp48}, 48, int'(VECS[v].dly));
            check(done && !busy && !err_timeout, "R3 done after reply", {done, busy, err_timeout}, 3'b100);
            check(resp == {88'd0, rsp48}, "R3 reply stored", resp, {88'd0, rsp48});
            check(err_crc == VECS[v].e_crc, "R8 crc flag", err_crc, VECS[v].e_crc);
            check(err_endbit == VECS[v].e_end, "R9 end flag", err_endbit, VECS[v].e_end);
            check(err_index == VECS[v].e_idx, "R7 index flag", err_index, VECS[v].e_idx);
            step();
            check(!done && !err_crc && !err_endbit && !err_index, "R12 pulse width",
                  {done, err_crc, err_endbit, err_index}, 0);
        end

        // R1 / R2: known frames, no-response kind
        send_cmd(6'd0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0, got, oe_ok);
        check(got == 48'h400000000095, "R1 known frame 0", got, 48'h400000000095);
        check(done && !busy && !cmd_oe, "R2 done at end bit", {done, busy, cmd_oe}, 3'b100);
        card_lvl = 1'b0;
        repeat (5) step();
        card_lvl = 1'b1;
        check(!busy && !done && !err_timeout, "R2 no listening", {busy, done, err_timeout}, 0);

        // R10: start mid-frame ignored
        send_cmd(6'd17, 32'h0, 2'b00, 1'b0, 1'b0, 1'b1, got, oe_ok);
        check(got == 48'h510000000055, "R10 frame intact", got, 48'h510000000055);
        check(done, "R10 done", done, 1);
        step();
        step();
        check(!busy && !cmd_oe, "R10 no second command", {busy, cmd_oe}, 0);

        // R4: long reply, index never checked
        pay    = 120'h0123456789ABCDEFFEDCBA98765432;
        rsp136 = {2'b00, 6'h3F, pay, ref_crc({16'd0, pay}, 120), 1'b1};
        send_cmd(6'd2, 32'h0, 2'b01, 1'b1, 1'b1, 1'b0, got, oe_ok);
        card_reply(rsp136, 136, 4);
        check(done && resp == rsp136, "R4 long reply", resp, rsp136);
        check(!err_crc && !err_index && !err_endbit, "R4 long no errors", {err_crc, err_index, err_endbit}, 0);
        step();
        rsp136[3] = ~rsp136[3];
        send_cmd(6'd2, 32'h0, 2'b01, 1'b1, 1'b1, 1'b0, got, oe_ok);
        card_reply(rsp136, 136, 0);
        check(done && err_crc && !err_index, "R4 long crc window", {done, err_crc, err_index}, 3'b110);
        step();

        // R5: timeout after 64 samples
        send_cmd(6'd5, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0, got, oe_ok);
        seen = 1'b0;
        for (int k = 0; k < 63; k++) begin
            step();
            if (err_timeout || done) seen = 1'b1;
        end
        check(busy && !seen, "R5 still waiting at 63", {busy, seen}, 2'b10);
        step();
        check(err_timeout && !done && !err_crc && !busy, "R5 timeout at 64",
              {err_timeout, done, err_crc, busy}, 4'b1000);
        step();

        // R6: wire conflict on the direction bit
        @(negedge clk);
        cmd_idx = 6'd9; cmd_arg = 32'h0; rsp_kind = 2'b10; start = 1'b1;
        step();
        start = 1'b0;
        jam = 1'b1;
        step();
        check(cmd_oe && busy && !err_crc, "R6 start bit not judged", {cmd_oe, busy, err_crc}, 3'b110);
        step();
        check(err_crc && err_timeout && !done && !cmd_oe && !busy, "R6 conflict abort",
              {err_crc, err_timeout, done, cmd_oe, busy}, 5'b11000);
        jam = 1'b0;
        step();

        // R11: soft reset while waiting
        send_cmd(6'd6, 32'h1, 2'b10, 1'b1, 1'b1, 1'b0, got, oe_ok);
        step();
        srst = 1'b1;
        step();
        srst = 1'b0;
        check(!busy && !cmd_oe && cmd_out && resp == '0, "R11 soft reset", {busy, cmd_oe, cmd_out}, 3'b001);
        seen = 1'b0;
        for (int k = 0; k < 70; k++) begin
            step();
            if (err_timeout || done || busy) seen = 1'b1;
        end
        check(!seen, "R11 no late events", seen, 0);

        // R12: start ignored without sd_ce
        sd_ce = 1'b0;
        start = 1'b1;
        step();
        start = 1'b0;
        sd_ce = 1'b1;
        step();
        check(!busy && !cmd_oe, "R12 start needs enable", {busy, cmd_oe}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule